// File: doc/BRIEF.md
# Stepped Soft-Start Reference Controller

This block produces the digital reference code that a regulator's error loop follows while its output is brought up from zero. After a start request the code climbs from zero to full scale in a fixed number of equal steps. Each step lasts a programmable number of clock ticks, and the code then stays at full scale. The same block decides when the power stage may begin switching. It takes a comparison flag from outside the block, which says whether the present output sits above the ramp value, and holds switching off while an output that was already charged still exceeds the ramp.

A dummy run can be requested, for example as a cool-down wait between overcurrent retries. It follows exactly the same step timing and completion pulse, but switching is never granted. An abort input, driven by an overcurrent trip or a disable, cuts switching at once and sends the ramp back to zero. The DAC, the error amplifier and the modulator sit outside this block.

Top module: `ssr_ramp_ctrl`

## Requirements
- R1: While reset is held and after its release with no start, the reference code is 0, the switching enable is low and the completion pulse is low.
- R2: A start (start_i high at a clock edge, abort_i low, no ramp in progress) clears the code to 0 at that edge. The code then rises by exactly one every STEP_TICKS cycles, so it equals k/STEP_TICKS (integer division) k cycles after the start edge.
- R3: Full scale is the code NUM_STEPS (64 by default). The code never exceeds it, and once reached it stays there until an abort or a new start.
- R4: ramp_done_o is high for exactly one cycle, the first cycle in which the code equals full scale. This applies to normal runs and to dummy runs.
- R5: During a normal run, switching enable stays low while out_above_i is 1 (1 means the output is above the current code). It rises one cycle after the first cycle in which out_above_i is 0.
- R6: Once switching is granted, it stays high through the rest of the ramp and at full scale even if out_above_i returns to 1. Only an abort or a new start from the full-scale hold clears it.
- R7: If out_above_i stays 1 for the whole ramp, switching enable rises in the same cycle in which the code first equals full scale.
- R8: dummy_i is sampled with the start. If it is 1, the run has the same code and completion timing, but switching enable stays low throughout the run and afterwards.
- R9: abort_i forces switching enable low combinationally in the same cycle. At the next edge the code becomes 0 and the block goes idle. Abort wins over a simultaneous start.
- R10: A start during a ramp in progress is ignored: the code and the grant continue unchanged. A start while holding at full scale restarts the ramp from 0 with switching withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to begin a ramp |
| abort_i | input | 1 | Overcurrent trip or disable; stops switching and clears the ramp |
| dummy_i | input | 1 | Sampled at start: 1 selects a timing-only run with no switching |
| out_above_i | input | 1 | 1 when the output is above the present reference code |
| ref_code_o | output | $clog2(NUM_STEPS+1) | Reference code to the DAC |
| sw_en_o | output | 1 | Power stage may switch |
| ramp_done_o | output | 1 | One-cycle pulse when the code reaches full scale |

## Verification
A corrupted tick counter or code register shows at ref_code_o as a step that arrives early or late, or as a jump of more than one. The first such step is visible within STEP_TICKS cycles of the fault, and the completion pulse moves with it. A wrong grant latch or a wrong captured mode bit shows at sw_en_o one cycle after a low comparison flag, or at the full-scale cycle. Such a fault can produce a grant that comes too early, a grant that drops while the comparison flag is high again, or switching during a dummy run. The bench models the output as a fixed pre-bias level compared against the code, so each grant point follows directly from that level.

// File: rtl/ssr_pkg.sv
// Shared types for the stepped soft-start reference controller.
package ssr_pkg;
    typedef enum logic [1:0] {
        RAMP_IDLE = 2'd0,
        RAMP_RUN  = 2'd1,
        RAMP_HOLD = 2'd2
    } ramp_state_t;
endpackage

// File: rtl/ssr_step_timer.sv
// Step timer: while run_i is high, pulses step_o once every STEP_TICKS cycles.
// Assumes STEP_TICKS >= 1. The count restarts from zero whenever run_i is low.
module ssr_step_timer #(
    parameter int STEP_TICKS = 10625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic step_o
);
    localparam int TW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(STEP_TICKS - 1);

    logic [TW-1:0] tick_q;

    // Tick counter: counts from 0 to LAST while running, otherwise stays at 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || tick_q == LAST) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign step_o = run_i && (tick_q == LAST);
endmodule

// File: rtl/ssr_code_counter.sv
// Reference code register: advances by one on each step until full scale,
// then holds there. A clear returns it to zero. Also emits a one-cycle done
// pulse that coincides with the first full-scale cycle.
module ssr_code_counter #(
    parameter int NUM_STEPS = 64,
    parameter int CODE_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    output logic [CODE_W-1:0] code_o,
    output logic              final_o,
    output logic              done_o
);
    localparam logic [CODE_W-1:0] FULL     = CODE_W'(NUM_STEPS);
    localparam logic [CODE_W-1:0] PRE_FULL = CODE_W'(NUM_STEPS - 1);

    logic [CODE_W-1:0] code_q;
    logic              done_q;

    // The last step of the ramp is about to take place.
    assign final_o = step_i && (code_q == PRE_FULL);

    // Code and done pulse update; a clear takes priority over a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (clear_i) begin
                code_q <= '0;
            end else if (step_i && code_q != FULL) begin
                code_q <= code_q + 1'b1;
                done_q <= final_o;
            end
        end
    end

    assign code_o = code_q;
    assign done_o = done_q;
endmodule

// File: rtl/ssr_switch_gate.sv
// Switching grant: latches on once the output is no longer above the ramp,
// or on the final step of the ramp. The latch stays on until it is cleared.
// Abort masks the output combinationally so the cut takes effect the same cycle.
module ssr_switch_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic arm_i,
    input  logic above_i,
    input  logic final_i,
    input  logic abort_i,
    output logic sw_en_o
);
    logic grant_q;

    // Grant latch: set while armed, cleared on a clear request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            grant_q <= 1'b0;
        end else if (arm_i && (!above_i || final_i)) begin
            grant_q <= 1'b1;
        end
    end

    assign sw_en_o = grant_q && !abort_i;
endmodule

// File: rtl/ssr_ramp_ctrl.sv
// Stepped soft-start reference controller (top). Sequences idle, ramp and
// full-scale hold; captures the dummy-mode bit when a start is accepted; and
// connects the step timer, the code counter and the switching gate.
// Assumes that out_above_i is a settled comparison of the output against
// ref_code_o.
module ssr_ramp_ctrl #(
    parameter  int STEP_TICKS = 10625,
    parameter  int NUM_STEPS  = 64,
    localparam int CODE_W     = $clog2(NUM_STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic              dummy_i,
    input  logic              out_above_i,
    output logic [CODE_W-1:0] ref_code_o,
    output logic              sw_en_o,
    output logic              ramp_done_o
);
    import ssr_pkg::*;

    ramp_state_t state_q;
    logic        dummy_q;
    logic        start_acc;
    logic        clear;
    logic        step;
    logic        final_step;
    logic        running;

    assign running   = (state_q == RAMP_RUN);
    assign start_acc = start_i && !abort_i && !running;
    assign clear     = abort_i || start_acc;

    // Sequencer: an abort returns to idle, a start enters the ramp, and the
    // final step enters the hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RAMP_IDLE;
            dummy_q <= 1'b0;
        end else if (abort_i) begin
            state_q <= RAMP_IDLE;
        end else if (start_acc) begin
            state_q <= RAMP_RUN;
            dummy_q <= dummy_i;
        end else if (running && final_step) begin
            state_q <= RAMP_HOLD;
        end
    end

    ssr_step_timer #(.STEP_TICKS(STEP_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running),
        .step_o (step)
    );

    ssr_code_counter #(.NUM_STEPS(NUM_STEPS), .CODE_W(CODE_W)) u_code (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .step_i  (step),
        .code_o  (ref_code_o),
        .final_o (final_step),
        .done_o  (ramp_done_o)
    );

    ssr_switch_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .arm_i   (running && !dummy_q),
        .above_i (out_above_i),
        .final_i (final_step),
        .abort_i (abort_i),
        .sw_en_o (sw_en_o)
    );
endmodule

// File: rtl/ssr_ramp_ctrl_chk.sv
// Property checker for ssr_ramp_ctrl, attached by bind. It only observes.
module ssr_ramp_ctrl_chk #(
    parameter int NUM_STEPS = 64,
    parameter int CODE_W    = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              abort_i,
    input logic              out_above_i,
    input logic [CODE_W-1:0] ref_code_o,
    input logic              sw_en_o,
    input logic              ramp_done_o,
    input logic              mode_dummy
);
    localparam logic [CODE_W-1:0] FULL = CODE_W'(NUM_STEPS);

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_code_o != $past(ref_code_o)) |->
        (ref_code_o == CODE_W'($past(ref_code_o) + 1'b1) || ref_code_o == '0));

    assert_code_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_code_o <= FULL);

    assert_done_at_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_done_o |-> (ref_code_o == FULL && $past(ref_code_o) == CODE_W'(NUM_STEPS - 1)));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_done_o |=> !ramp_done_o);

    assert_grant_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_en_o) |-> (!$past(out_above_i) || ref_code_o == FULL));

    assert_grant_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en_o && !start_i) |=> (sw_en_o || abort_i));

    assert_dummy_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_dummy |-> !sw_en_o);

    assert_abort_cut_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |-> !sw_en_o);

    assert_abort_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (ref_code_o == '0));
endmodule

bind ssr_ramp_ctrl ssr_ramp_ctrl_chk #(.NUM_STEPS(NUM_STEPS), .CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .abort_i     (abort_i),
    .out_above_i (out_above_i),
    .ref_code_o  (ref_code_o),
    .sw_en_o     (sw_en_o),
    .ramp_done_o (ramp_done_o),
    .mode_dummy  (dummy_q)
);

// File: tb/ssr_ramp_ctrl_bench.sv
// Self-checking bench for ssr_ramp_ctrl. The regulator output is modelled as a
// fixed pre-bias level compared against the reference code.
module ssr_ramp_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ST         = 4;
    localparam int NS         = 64;
    localparam int RAMP_END   = NS * ST;
    localparam int TRACE_LEN  = RAMP_END + 2 * ST;
    localparam int WATCHDOG   = 150000;

    // Vector table: dummy mode, pre-bias level, raise the level after the grant.
    localparam int NV = 6;
    localparam int VEC_DUMMY [NV] = '{0, 0, 0, 0, 0, 1};
    localparam int VEC_PRE   [NV] = '{0, 20, 64, 90, 10, 0};
    localparam int VEC_BUMP  [NV] = '{0, 0, 0, 0, 1, 0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       abort_i = 1'b0;
    logic       dummy_i = 1'b0;
    logic       out_above_i;
    logic [6:0] ref_code_o;
    logic       sw_en_o;
    logic       ramp_done_o;
    int         prebias = 0;
    int         checks = 0;
    int         failures = 0;
    int         cycles = 0;

    assign out_above_i = (prebias > int'(ref_code_o));

    ssr_ramp_ctrl #(.STEP_TICKS(ST), .NUM_STEPS(NS)) u_ssr_ramp_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .abort_i     (abort_i),
        .dummy_i     (dummy_i),
        .out_above_i (out_above_i),
        .ref_code_o  (ref_code_o),
        .sw_en_o     (sw_en_o),
        .ramp_done_o (ramp_done_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog all-reqs act=%0d exp<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic go_idle();
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        @(negedge clk);
    endtask

    // Starts a ramp; on return the current time is the negedge after the start edge (k = 0).
    task automatic do_start(input bit dm);
        dummy_i = dm;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        dummy_i = 1'b0;
    endtask

    task automatic run_vector(input int v);
        int    g;
        int    bad_r2, bad_r3, bad_sw, bad_done;
        int    a_r2, e_r2, a_r3, a_sw, e_sw, k_sw, a_dn, k_dn;
        string sw_req;
        bad_r2 = 0; bad_r3 = 0; bad_sw = 0; bad_done = 0;
        a_r2 = 0; e_r2 = 0; a_r3 = 0; a_sw = 0; e_sw = 0; k_sw = 0; a_dn = 0; k_dn = 0;
        g = (VEC_PRE[v] >= NS) ? RAMP_END : VEC_PRE[v] * ST + 1;
        sw_req = (VEC_DUMMY[v] != 0) ? "R8" : (VEC_BUMP[v] != 0) ? "R6" :
                 (VEC_PRE[v] >= NS) ? "R7" : "R5";
        go_idle();
        prebias = VEC_PRE[v];
        do_start(VEC_DUMMY[v] != 0);
        for (int k = 0; k <= TRACE_LEN; k++) begin
            int exp_code;
            int exp_sw;
            int exp_dn;
            if (k > 0) @(negedge clk);
            exp_code = (k / ST > NS) ? NS : k / ST;
            exp_sw   = (VEC_DUMMY[v] == 0 && k >= g) ? 1 : 0;
            exp_dn   = (k == RAMP_END) ? 1 : 0;
            if (int'(ref_code_o) != exp_code) begin
                if (k < RAMP_END) begin
                    if (bad_r2 == 0) begin a_r2 = int'(ref_code_o); e_r2 = exp_code; end
                    bad_r2++;
                end else begin
                    if (bad_r3 == 0) a_r3 = int'(ref_code_o);
                    bad_r3++;
                end
            end
            if (int'(sw_en_o) != exp_sw) begin
                if (bad_sw == 0) begin a_sw = int'(sw_en_o); e_sw = exp_sw; k_sw = k; end
                bad_sw++;
            end
            if (int'(ramp_done_o) != exp_dn) begin
                if (bad_done == 0) begin a_dn = int'(ramp_done_o); k_dn = k; end
                bad_done++;
            end
            // R6: raise the output above the ramp once switching has been granted.
            if (VEC_BUMP[v] != 0 && k == g) prebias = 100;
        end
        chk(bad_r2 == 0, "R2", $sformatf("vec%0d code during ramp", v), a_r2, e_r2);
        chk(bad_r3 == 0, "R3", $sformatf("vec%0d code held at full", v), a_r3, NS);
        chk(bad_sw == 0, sw_req, $sformatf("vec%0d sw_en at k=%0d", v, k_sw), a_sw, e_sw);
        chk(bad_done == 0, "R4", $sformatf("vec%0d done at k=%0d", v, k_dn), a_dn, 1 - a_dn);
    endtask

    initial begin
        // R1: state during reset and after its release.
        repeat (3) @(negedge clk);
        chk(ref_code_o == 0 && !sw_en_o && !ramp_done_o, "R1", "outputs in reset",
            int'(ref_code_o) + int'(sw_en_o) + int'(ramp_done_o), 0);
        rst_n = 1'b1;
        repeat (ST * 3) @(negedge clk);
        chk(ref_code_o == 0 && !sw_en_o && !ramp_done_o, "R1", "idle after reset",
            int'(ref_code_o) + int'(sw_en_o) + int'(ramp_done_o), 0);

        for (int v = 0; v < NV; v++) run_vector(v);

        // R10: start while holding at full scale restarts from zero.
        go_idle();
        prebias = 0;
        do_start(1'b0);
        repeat (RAMP_END + 2) @(negedge clk);
        chk(sw_en_o == 1'b1, "R10", "granted before restart", int'(sw_en_o), 1);
        do_start(1'b0);
        chk(ref_code_o == 0, "R10", "code after restart", int'(ref_code_o), 0);
        chk(sw_en_o == 1'b0, "R10", "grant cleared by restart", int'(sw_en_o), 0);
        @(negedge clk);
        chk(sw_en_o == 1'b1, "R5", "grant one cycle after restart", int'(sw_en_o), 1);

        // R10: start during a ramp is ignored.
        go_idle();
        do_start(1'b0);
        repeat (2 * ST + 2) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (ST - 3) @(negedge clk);
        chk(ref_code_o == 3, "R10", "code after ignored start", int'(ref_code_o), 3);
        chk(sw_en_o == 1'b1, "R10", "grant kept after ignored start", int'(sw_en_o), 1);

        // R9: abort cuts switching in the same cycle and zeroes the code next cycle.
        abort_i = 1'b1;
        #1;
        chk(sw_en_o == 1'b0, "R9", "sw_en during abort cycle", int'(sw_en_o), 0);
        @(negedge clk);
        abort_i = 1'b0;
        chk(ref_code_o == 0, "R9", "code after abort", int'(ref_code_o), 0);
        repeat (2 * ST) @(negedge clk);
        chk(ref_code_o == 0 && !sw_en_o, "R9", "idle after abort",
            int'(ref_code_o) + int'(sw_en_o), 0);

        // R9: abort beats a simultaneous start.
        abort_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        start_i = 1'b0;
        repeat (3 * ST) @(negedge clk);
        chk(ref_code_o == 0 && !sw_en_o, "R9", "abort with start stays idle",
            int'(ref_code_o) + int'(sw_en_o), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule